// File: doc/BRIEF.md
# Password-Gated Configuration Register Bank

This block holds a small bank of 8-bit configuration registers on a simple I/O bus. The bus has a 12-bit address, separate write and read data buses and single-cycle strobes. After reset the bank is locked. A locked bank answers every read in its window with 0xFF, the value a floating bus would give, and it ignores writes. Writing the unlock key to the key address opens a one-shot gate. The very next bus access, at any address, uses up the gate. If that access is a write or read of a bank register, it stores or returns real data.

A two-byte sequence on the key address moves the bank into indirect mode, where it stays until reset. In indirect mode the direct window goes silent. Software first writes an index register, then reads or writes a data register, and no key is needed any more. The indexed space also holds a read-only revision code. All register contents are exported in parallel for downstream decoders.

Top module: `cfg_gate_bank`

## Requirements
- R1: After reset, and whenever the gate is closed in direct mode, a read at any address from 0xF8D to 0xF93 drives `rdata_oe` high with `rdata` = 0xFF. All registers reset to 0x00.
- R2: Writing the key (default 0xE2) to 0xF8F while locked opens the gate for exactly one following access. The access after that again sees the locked behaviour.
- R3: A write at 0xF8D+k (k = 0..6) made while the gate is open stores the byte. It appears on `cfg_regs[8k+7:8k]` and is returned by a later read of that address made through a fresh unlock.
- R4: A write to 0xF8F of any value other than the key, the mode byte 0xE4 or the data written while open leaves the gate closed. A write to the window while locked changes no register.
- R5: Any access uses up an open gate, including a read or write outside the window.
- R6: Writing 0xE4 and then, as the very next access, 0x80 to 0xF8F enters indirect mode. Indirect mode lasts until reset, and no key is needed for any later access.
- R7: In indirect mode, a write to 0xE0E sets the index. Reads and writes at 0xE0F then reach the register at address 0xF8C + index, for index 1..7.
- R8: In indirect mode, index 18 is a read-only revision register that returns REV_ID (default 0x3A). Writes to it change nothing.
- R9: If the access right after 0xE4 is anything other than a write of 0x80 to 0xF8F, the bank returns to locked direct mode, and the key opens it as before.
- R10: `rdata_oe` is high only during `rd_stb`, and only for the window in direct mode or for 0xE0F in indirect mode. Reads of the direct window in indirect mode are not driven.
- R11: While the gate is open, a write to 0xF8F stores into the register at that address and is not taken as a key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | I/O address |
| wdata | input | 8 | Write data |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Read data, valid while `rdata_oe` is high |
| rdata_oe | output | 1 | Read data drive enable |
| cfg_regs | output | 56 | Register contents, register k in bits 8k+7:8k |

## Verification
A gate left open one access too long shows up at once: the second read of a window address returns stored data instead of 0xFF. A gate that never opens shows up as missing values on `cfg_regs` in the cycle after the write. A wrong mode state shows on the next read. Such a read is either undriven where data was expected, or driven at a direct address that should be silent. A wrong index state returns the wrong register byte on the very next data-port read.

// File: rtl/cfg_gate_bank.sv
module cfg_gate_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int N_REGS = 7,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'hF8C,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'hF8F,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 12'hE0E,
  parameter logic [ADDR_W-1:0] DAT_ADDR  = 12'hE0F,
  parameter logic [DATA_W-1:0] KEY       = 8'hE2,
  parameter logic [DATA_W-1:0] MODE_KEY  = 8'hE4,
  parameter logic [DATA_W-1:0] MODE_OK   = 8'h80,
  parameter int ID_INDEX = 18,
  parameter logic [DATA_W-1:0] REV_ID    = 8'h3A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wr_stb,
  input  logic                     rd_stb,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_oe,
  output logic [N_REGS*DATA_W-1:0] cfg_regs
);
  localparam logic [ADDR_W-1:0] LAST = BANK_BASE + ADDR_W'(N_REGS);

  typedef enum logic [1:0] {ST_LOCKED, ST_OPEN, ST_ARMED, ST_INDIRECT} gate_t;

  gate_t state, nxt;
  logic [DATA_W-1:0] idx;
  logic [DATA_W-1:0] regs [N_REGS];

  logic [ADDR_W-1:0] offs;
  logic in_win, access, key_wr, idx_hit, indirect;

  assign offs     = addr - BANK_BASE;
  assign in_win   = (addr > BANK_BASE) && (addr <= LAST);
  assign access   = rd_stb | wr_stb;
  assign key_wr   = wr_stb && (addr == KEY_ADDR);
  assign indirect = (state == ST_INDIRECT);
  assign idx_hit  = (idx >= 1) && (idx <= DATA_W'(N_REGS));

  always_comb begin
    nxt = state;
    case (state)
      ST_LOCKED:
        if (key_wr && wdata == KEY)           nxt = ST_OPEN;
        else if (key_wr && wdata == MODE_KEY) nxt = ST_ARMED;
      ST_OPEN:
        if (access) nxt = ST_LOCKED;
      ST_ARMED:
        if (access) nxt = (key_wr && wdata == MODE_OK) ? ST_INDIRECT : ST_LOCKED;
      default: nxt = ST_INDIRECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOCKED;
      idx   <= '0;
    end else begin
      state <= nxt;
      if (indirect && wr_stb && addr == IDX_ADDR) idx <= wdata;
    end
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic dir_we, ind_we;
    assign dir_we = (state == ST_OPEN) && wr_stb && in_win && (offs == ADDR_W'(i + 1));
    assign ind_we = indirect && wr_stb && (addr == DAT_ADDR) && (idx == DATA_W'(i + 1));
    always_ff @(posedge clk) begin
      if (!rst_n)                regs[i] <= '0;
      else if (dir_we || ind_we) regs[i] <= wdata;
    end
    assign cfg_regs[i*DATA_W +: DATA_W] = regs[i];
  end

  always_comb begin
    rdata_oe = 1'b0;
    rdata    = '1;
    if (rd_stb && !indirect && in_win) begin
      rdata_oe = 1'b1;
      if (state == ST_OPEN)
        for (int i = 0; i < N_REGS; i++)
          if (offs == ADDR_W'(i + 1)) rdata = regs[i];
    end else if (rd_stb && indirect && addr == DAT_ADDR) begin
      rdata_oe = 1'b1;
      if (idx == DATA_W'(ID_INDEX)) rdata = REV_ID;
      else if (idx_hit)
        for (int i = 0; i < N_REGS; i++)
          if (idx == DATA_W'(i + 1)) rdata = regs[i];
    end
  end
endmodule

module cfg_gate_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int N_REGS = 7,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'hF8C,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'hF8F,
  parameter logic [ADDR_W-1:0] DAT_ADDR  = 12'hE0F,
  parameter logic [DATA_W-1:0] MODE_OK   = 8'h80,
  parameter int ID_INDEX = 18,
  parameter logic [DATA_W-1:0] REV_ID    = 8'h3A
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        wdata,
  input logic                     wr_stb,
  input logic                     rd_stb,
  input logic [DATA_W-1:0]        rdata,
  input logic                     rdata_oe,
  input logic [N_REGS*DATA_W-1:0] cfg_regs,
  input logic [1:0]               gate_st,
  input logic [DATA_W-1:0]        idx
);
  logic win;
  assign win = (addr > BANK_BASE) && (addr <= BANK_BASE + ADDR_W'(N_REGS));

  assert_locked_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_st == 2'd0 && rd_stb && win) |-> (rdata_oe && rdata == '1));

  assert_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_st == 2'd1 && (rd_stb || wr_stb)) |=> (gate_st == 2'd0));

  assert_regs_need_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg_regs));

  assert_indirect_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_st == 2'd3 |=> gate_st == 2'd3);

  assert_rev_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_st == 2'd3 && rd_stb && addr == DAT_ADDR && idx == DATA_W'(ID_INDEX))
      |-> (rdata_oe && rdata == REV_ID));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_st == 2'd2 && (rd_stb || wr_stb) && !(wr_stb && addr == KEY_ADDR && wdata == MODE_OK))
      |=> gate_st == 2'd0);

  assert_oe_only_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> !rdata_oe);
endmodule

bind cfg_gate_bank cfg_gate_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_REGS(N_REGS), .BANK_BASE(BANK_BASE),
  .KEY_ADDR(KEY_ADDR), .DAT_ADDR(DAT_ADDR), .MODE_OK(MODE_OK),
  .ID_INDEX(ID_INDEX), .REV_ID(REV_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .rdata(rdata), .rdata_oe(rdata_oe), .cfg_regs(cfg_regs),
  .gate_st(state), .idx(idx)
);

// File: tb/cfg_gate_bank_test.sv
`timescale 1ns/1ps
module cfg_gate_bank_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_stb = 0, rd_stb = 0;
  logic [7:0] rdata;
  logic rdata_oe;
  logic [55:0] cfg_regs;

  int vectors = 0, errors = 0;
  logic [7:0] q_data[$];
  logic q_oe[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  cfg_gate_bank uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rdata(rdata), .rdata_oe(rdata_oe),
    .cfg_regs(cfg_regs));

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr_stb = 1;
    @(posedge clk); #1 wr_stb = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] d, input logic oe, input string tag);
    q_data.push_back(d); q_oe.push_back(oe); q_tag.push_back(tag);
    @(posedge clk); #1 addr = a; rd_stb = 1;
    @(posedge clk); #1 rd_stb = 0;
  endtask

  task automatic unlock();
    wr(12'hF8F, 8'hE2);
  endtask

  task automatic chk_reg(input int k, input logic [7:0] d, input string tag);
    vectors++;
    if (cfg_regs[k*8 +: 8] !== d) begin
      errors++;
      $display("FAIL %s: cfg_regs byte %0d = %02h, expected %02h", tag, k, cfg_regs[k*8 +: 8], d);
    end
  endtask

  always @(negedge clk) begin
    if (rd_stb) begin
      if (q_oe.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, actual %02h/%0b, expected none", rdata, rdata_oe);
      end else begin
        logic [7:0] ed; logic eo; string et;
        ed = q_data.pop_front(); eo = q_oe.pop_front(); et = q_tag.pop_front();
        vectors++;
        if (rdata_oe !== eo || (eo && rdata !== ed)) begin
          errors++;
          $display("FAIL %s: read %02h oe=%0b, expected %02h oe=%0b", et, rdata, rdata_oe, ed, eo);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int k = 0; k < 7; k++) chk_reg(k, 8'h00, "R1 reset value");
    rd(12'hF8D, 8'hFF, 1, "R1 locked read F8D");
    rd(12'hF93, 8'hFF, 1, "R1 locked read F93");
    rd(12'h300, 8'h00, 0, "R10 outside window undriven");
    // R2 / R3 one-shot write
    unlock(); wr(12'hF8D, 8'hA5);
    chk_reg(0, 8'hA5, "R3 write stored");
    rd(12'hF8D, 8'hFF, 1, "R2 gate closed after one access");
    unlock(); rd(12'hF8D, 8'hA5, 1, "R3 read back");
    rd(12'hF8D, 8'hFF, 1, "R2 closed after read");
    unlock(); wr(12'hF8D, 8'h25);
    unlock(); rd(12'hF8D, 8'h25, 1, "R3 toggled bit reads back");
    // R4 wrong key
    wr(12'hF8F, 8'h11); wr(12'hF90, 8'h77);
    chk_reg(3, 8'h00, "R4 wrong key write ignored");
    rd(12'hF90, 8'hFF, 1, "R4 still locked");
    // R5 outside access consumes
    unlock(); rd(12'h300, 8'h00, 0, "R5 outside read");
    wr(12'hF91, 8'h33);
    chk_reg(4, 8'h00, "R5 gate consumed by outside access");
    // R11 key address as data while open
    unlock(); wr(12'hF8F, 8'h5C);
    chk_reg(2, 8'h5C, "R11 write to shared address stored");
    rd(12'hF8F, 8'hFF, 1, "R11 locked afterwards");
    unlock(); rd(12'hF8F, 8'h5C, 1, "R11 read back");
    // R9 abort
    wr(12'hF8F, 8'hE4); wr(12'hF8F, 8'h81); wr(12'hF92, 8'h44);
    chk_reg(5, 8'h00, "R9 aborted sequence leaves locked");
    rd(12'hF92, 8'hFF, 1, "R9 locked after abort");
    unlock(); wr(12'hF92, 8'h44);
    chk_reg(5, 8'h44, "R9 key works after abort");
    // R6 / R7 / R8 indirect
    wr(12'hF8F, 8'hE4); wr(12'hF8F, 8'h80);
    wr(12'hE0E, 8'h07); wr(12'hE0F, 8'h99);
    chk_reg(6, 8'h99, "R7 indirect write");
    rd(12'hE0F, 8'h99, 1, "R6 no key needed");
    rd(12'hE0F, 8'h99, 1, "R6 second keyless read");
    wr(12'hE0E, 8'h01);
    rd(12'hE0F, 8'h25, 1, "R7 indexed read");
    rd(12'hF8D, 8'h00, 0, "R10 direct window silent in indirect mode");
    rd(12'hE0E, 8'h00, 0, "R10 index port not driven");
    wr(12'hE0E, 8'd18);
    rd(12'hE0F, 8'h3A, 1, "R8 revision read");
    wr(12'hE0F, 8'h00);
    rd(12'hE0F, 8'h3A, 1, "R8 revision read-only");
    chk_reg(0, 8'h25, "R8 write to revision index touches nothing");
    chk_reg(6, 8'h99, "R8 write to revision index touches nothing");
    repeat (2) @(posedge clk);
    if (q_oe.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads outstanding, expected 0", q_oe.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule